// File: doc/BRIEF.md
# Serial Synthesizer Configuration Loader

This block takes 20-bit configuration words from a three-wire serial port: a serial clock, a data line and a load strobe. Bits are shifted in, most significant first, while the load strobe is held low. When the strobe returns high, the two lowest bits of the word pick the destination. The rest of the word is stored in one of three registers: the reference divider, the swallow/main divider pair, or the operating-mode register. A word is stored only if exactly 20 bits arrived during that low window.

All serial inputs are oversampled by the system clock. Each passes through a two-flop synchronizer, and edge detection on the synchronized lines forms the shift and load strobes. The block also derives the power outputs. Two enable pins drive the local-oscillator buffer enables directly. They are also decoded into a power state. The synthesizer enable is the logical OR of the two pins, ANDed with the PLL-enable bit of the mode register. Stored contents do not depend on the pins, so a configuration written once stays valid through any number of power-down periods.

Top module: `synth_cfg_loader`

## Requirements
- R1: After synchronous reset, all registers read zero, `synth_en` is 0 and `pwr_state` follows the pins.
- R2: Bits are sampled on rising serial-clock edges, and only while `ser_le` is low. The first bit is word bit 19 and the last is bit 0. Serial-clock edges while `ser_le` is high have no effect.
- R3: On a rising edge of `ser_le`, a word with {bit1,bit0} = 00 loads `ref_div` from word bits 16:2.
- R4: {bit1,bit0} = 10 loads `a_div` from bits 8:2 and `b_div` from bits 19:9.
- R5: {bit1,bit0} = 01 loads `mode_word` (16 bits) from word bits 17:2. Mode bits 1, 9, 10, 11 and 12 are always stored as zero.
- R6: {bit1,bit0} = 11 changes no register.
- R7: A word with a bit count other than 20 between the falling and the rising edge of `ser_le` is discarded, and no register changes.
- R8: `synth_en` = `mode_word[15]` AND (`pe_a` OR `pe_b`).
- R9: `lo_en_a` equals `pe_a` and `lo_en_b` equals `pe_b`. `pwr_state` = {pe_a,pe_b}: 00 power-down, 01 inactive, 10 transmit, 11 receive.
- R10: Register contents are kept unchanged through power-down. Words can still be loaded while both pins are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Load strobe, active-low shift window |
| pe_a | input | 1 | Enable pin A (transmit side) |
| pe_b | input | 1 | Enable pin B (receive side) |
| ref_div | output | 15 | Reference divider value |
| a_div | output | 7 | Swallow counter value |
| b_div | output | 11 | Main counter value |
| mode_word | output | 16 | Operating-mode register |
| synth_en | output | 1 | Synthesizer enable |
| lo_en_a | output | 1 | LO buffer enable A |
| lo_en_b | output | 1 | LO buffer enable B |
| pwr_state | output | 2 | Decoded power state |

## Verification
The hardest case to reach is a load strobe that closes on a wrong bit count. Only the count decides whether a correct-looking word is stored. The bench therefore sends frames of 19 and 21 bits whose select and payload would otherwise be valid. It also toggles the serial clock while the strobe is high, just before a good frame. After each of these it reads all registers back at the ports.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    parameter int WORD_W = 20;
    parameter int R_W    = 15;
    parameter int A_W    = 7;
    parameter int B_W    = 11;
    parameter int M_W    = 16;
    parameter int SEL_W  = 2;
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int PLL_BIT = 15;
    localparam logic [M_W-1:0] M_ZERO_MASK = 16'h1E02;

    typedef enum logic [SEL_W-1:0] {
        SEL_REF  = 2'b00,
        SEL_MODE = 2'b01,
        SEL_AB   = 2'b10,
        SEL_NONE = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        PS_DOWN = 2'b00,
        PS_IDLE = 2'b01,
        PS_TX   = 2'b10,
        PS_RX   = 2'b11
    } pwr_e;

    typedef struct packed {
        logic [B_W-1:0] b;
        logic [A_W-1:0] a;
    } ab_t;

    function automatic pwr_e pwr_decode(input logic pa, input logic pb);
        return pwr_e'({pa, pb});
    endfunction
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1, s2, s3;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                s1[i] <= 1'b0;
                s2[i] <= 1'b0;
                s3[i] <= 1'b0;
            end else begin
                s1[i] <= raw[i];
                s2[i] <= s1[i];
                s3[i] <= s2[i];
            end
        end
        assign rise[i] = s2[i] & ~s3[i];
        assign fall[i] = ~s2[i] & s3[i];
    end

    assign lvl = s2;
endmodule

// File: rtl/scl_shift.sv
module scl_shift
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              din,
    input  logic              clear,
    output logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
            cnt  <= '0;
        end else begin
            if (shift_en)
                word <= {word[WORD_W-2:0], din};
            if (clear)
                cnt <= '0;
            else if (shift_en && cnt != CNT_SAT)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_regs.sv
module scl_regs
    import synth_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic              word_ok,
    input  logic [WORD_W-1:0] word,
    output logic [R_W-1:0]    ref_q,
    output ab_t               ab_q,
    output logic [M_W-1:0]    mode_q,
    output logic              wr_ref,
    output logic              wr_ab,
    output logic              wr_mode
);
    sel_e sel;
    logic go;

    assign sel     = sel_e'(word[SEL_W-1:0]);
    assign go      = commit & word_ok;
    assign wr_ref  = go && sel == SEL_REF;
    assign wr_ab   = go && sel == SEL_AB;
    assign wr_mode = go && sel == SEL_MODE;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            ab_q   <= '0;
            mode_q <= '0;
        end else begin
            if (wr_ref)
                ref_q <= word[SEL_W +: R_W];
            if (wr_ab)
                ab_q <= ab_t'(word[WORD_W-1:SEL_W]);
            if (wr_mode)
                mode_q <= word[SEL_W +: M_W] & ~M_ZERO_MASK;
        end
    end
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
    import synth_cfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_le,
    input  logic           pe_a,
    input  logic           pe_b,
    output logic [R_W-1:0] ref_div,
    output logic [A_W-1:0] a_div,
    output logic [B_W-1:0] b_div,
    output logic [M_W-1:0] mode_word,
    output logic           synth_en,
    output logic           lo_en_a,
    output logic           lo_en_b,
    output logic [1:0]     pwr_state
);
    localparam int IDX_CLK = 0;
    localparam int IDX_DAT = 1;
    localparam int IDX_LE  = 2;

    logic [2:0]        lvl, rise, fall;
    logic              shift_en, commit, word_ok;
    logic              wr_ref, wr_ab, wr_mode;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  bit_cnt;
    ab_t               ab_q;

    scl_sync #(.W(3)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .raw  ({ser_le, ser_data, ser_clk}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    assign shift_en = rise[IDX_CLK] & ~lvl[IDX_LE];
    assign commit   = rise[IDX_LE];
    assign word_ok  = bit_cnt == CNT_W'(WORD_W);

    scl_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .din      (lvl[IDX_DAT]),
        .clear    (commit | fall[IDX_LE]),
        .word     (word),
        .cnt      (bit_cnt)
    );

    scl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .word_ok (word_ok),
        .word    (word),
        .ref_q   (ref_div),
        .ab_q    (ab_q),
        .mode_q  (mode_word),
        .wr_ref  (wr_ref),
        .wr_ab   (wr_ab),
        .wr_mode (wr_mode)
    );

    assign a_div     = ab_q.a;
    assign b_div     = ab_q.b;
    assign lo_en_a   = pe_a;
    assign lo_en_b   = pe_b;
    assign pwr_state = pwr_decode(pe_a, pe_b);
    assign synth_en  = mode_word[PLL_BIT] & (pe_a | pe_b);
endmodule

// File: rtl/synth_cfg_loader_chk.sv
module synth_cfg_loader_chk
    import synth_cfg_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           pe_a,
    input logic           pe_b,
    input logic           synth_en,
    input logic [R_W-1:0] ref_div,
    input logic [A_W-1:0] a_div,
    input logic [B_W-1:0] b_div,
    input logic [M_W-1:0] mode_word,
    input logic           commit,
    input logic           word_ok,
    input logic           wr_ref,
    input logic           wr_ab,
    input logic           wr_mode
);
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_ref, wr_ab, wr_mode})); // R6

    AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode_word & M_ZERO_MASK) == '0); // R5

    AST_PINS_OFF: assert property (@(posedge clk) disable iff (rst)
        !(pe_a | pe_b) |-> !synth_en); // R8

    AST_BAD_COUNT: assert property (@(posedge clk) disable iff (rst)
        (commit && !word_ok) |=> ($stable(ref_div) && $stable(a_div)
                                  && $stable(b_div) && $stable(mode_word))); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(ref_div) && $stable(mode_word)
                     && $stable(a_div) && $stable(b_div))); // R10
endmodule

bind synth_cfg_loader synth_cfg_loader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pe_a      (pe_a),
    .pe_b      (pe_b),
    .synth_en  (synth_en),
    .ref_div   (ref_div),
    .a_div     (a_div),
    .b_div     (b_div),
    .mode_word (mode_word),
    .commit    (commit),
    .word_ok   (word_ok),
    .wr_ref    (wr_ref),
    .wr_ab     (wr_ab),
    .wr_mode   (wr_mode)
);

// File: tb/synth_cfg_loader_test.sv
module synth_cfg_loader_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b1;
    logic pe_a = 1'b0, pe_b = 1'b0;
    logic [14:0] ref_div;
    logic [6:0]  a_div;
    logic [10:0] b_div;
    logic [15:0] mode_word;
    logic synth_en, lo_en_a, lo_en_b;
    logic [1:0] pwr_state;
    int checks = 0;
    int errors = 0;
    logic [15:0] exp_mode = '0;

    always #2.5 clk = ~clk;

    synth_cfg_loader uut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .pe_a(pe_a), .pe_b(pe_b), .ref_div(ref_div),
        .a_div(a_div), .b_div(b_div), .mode_word(mode_word),
        .synth_en(synth_en), .lo_en_a(lo_en_a), .lo_en_b(lo_en_b),
        .pwr_state(pwr_state)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bit(input logic b);
        ser_data = b;
        ser_clk  = 1'b0;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(4);
        ser_clk = 1'b0;
    endtask

    // sends the nbits lowest bits of w, most significant first
    task automatic send(input logic [31:0] w, input int nbits);
        ser_le = 1'b0;
        wait_clk(4);
        for (int i = nbits - 1; i >= 0; i--) pulse_bit(w[i]);
        wait_clk(4);
        ser_le = 1'b1;
        wait_clk(10);
    endtask

    function automatic logic [31:0] w_ref(input logic [14:0] r);
        return {12'h000, 3'b111, r, 2'b00};
    endfunction
    function automatic logic [31:0] w_ab(input logic [6:0] a, input logic [10:0] b);
        return {12'h000, b, a, 2'b10};
    endfunction
    function automatic logic [31:0] w_mode(input logic [15:0] m);
        return {12'h000, 2'b11, m, 2'b01};
    endfunction

    task automatic t_reset();
        check("R1 ref_div", 32'(ref_div), 0);
        check("R1 a/b", {a_div, b_div}, 0);
        check("R1 mode", 32'(mode_word), 0);
        check("R1 synth_en", 32'(synth_en), 0);
    endtask

    task automatic t_ref();
        send(w_ref(15'h5A3C), 20);
        check("R3 ref load", 32'(ref_div), 32'h5A3C);
        send(w_ref(15'h7FFF), 20);
        check("R3 ref all ones", 32'(ref_div), 32'h7FFF);
    endtask

    task automatic t_ab();
        send(w_ab(7'h55, 11'h6B3), 20);
        check("R4 a_div", 32'(a_div), 32'h55);
        check("R4 b_div", 32'(b_div), 32'h6B3);
        check("R2 order keeps ref", 32'(ref_div), 32'h7FFF);
    endtask

    task automatic t_mode();
        send(w_mode(16'hFFFF), 20);
        exp_mode = 16'hFFFF & ~16'h1E02;
        check("R5 mode fixed zeros", 32'(mode_word), 32'(exp_mode));
        send(w_mode(16'h8421), 20);
        exp_mode = 16'h8421 & ~16'h1E02;
        check("R5 mode pattern", 32'(mode_word), 32'(exp_mode));
    endtask

    task automatic t_sel_none();
        send({12'h000, 18'h3FFFF, 2'b11}, 20);
        check("R6 ref kept", 32'(ref_div), 32'h7FFF);
        check("R6 ab kept", {a_div, b_div}, {7'h55, 11'h6B3});
        check("R6 mode kept", 32'(mode_word), 32'(exp_mode));
    endtask

    task automatic t_count();
        send(w_ref(15'h0123), 19);
        check("R7 short word", 32'(ref_div), 32'h7FFF);
        send({w_ref(15'h0456), 1'b0}, 21);
        check("R7 long word", 32'(ref_div), 32'h7FFF);
        send(w_ab(7'h01, 11'h002), 21);
        check("R7 long ab", {a_div, b_div}, {7'h55, 11'h6B3});
    endtask

    task automatic t_le_high();
        pulse_bit(1'b1);
        pulse_bit(1'b0);
        pulse_bit(1'b1);
        check("R2 clk with le high", 32'(ref_div), 32'h7FFF);
        send(w_ref(15'h2222), 20);
        check("R2 next frame clean", 32'(ref_div), 32'h2222);
    endtask

    task automatic t_power();
        for (int p = 0; p < 4; p++) begin
            pe_a = p[1];
            pe_b = p[0];
            wait_clk(2);
            check("R9 pwr_state", 32'(pwr_state), 32'(p));
            check("R9 lo enables", {lo_en_a, lo_en_b}, 32'(p));
            check("R8 synth_en m15=1", 32'(synth_en), 32'(p != 0));
        end
        send(w_mode(16'h0001), 20);
        exp_mode = 16'h0001;
        check("R8 synth_en m15=0", 32'(synth_en), 0);
        send(w_mode(16'h8001), 20);
        exp_mode = 16'h8001;
        check("R8 synth_en back", 32'(synth_en), 1);
    endtask

    task automatic t_retain();
        pe_a = 1'b0;
        pe_b = 1'b0;
        wait_clk(50);
        check("R10 ref held", 32'(ref_div), 32'h2222);
        check("R10 mode held", 32'(mode_word), 32'(exp_mode));
        check("R10 synth off", 32'(synth_en), 0);
        send(w_ab(7'h0F, 11'h400), 20);
        check("R10 load in down", {a_div, b_div}, {7'h0F, 11'h400});
        pe_b = 1'b1;
        wait_clk(2);
        check("R10 wake", 32'(synth_en), 1);
        check("R10 mode after wake", 32'(mode_word), 32'(exp_mode));
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(10);
        t_reset();
        t_ref();
        t_ab();
        t_mode();
        t_sel_none();
        t_count();
        t_le_high();
        t_power();
        t_retain();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule